// File: doc/BRIEF.md
# Audio Serial Frame Transmitter

This block turns a stream of parallel audio samples into a serial line. It always acts as clock master and drives three outputs: a bit clock, a frame sync and a data line. The bit clock is divided down from the system clock. A static configuration selects the following:

- one of four framing styles: two-wire-style stereo, left-aligned, and two short-pulse styles;
- the sample word width;
- the bit order;
- one or two word slots per frame;
- a mask bit for each slot;
- separate polarity inversion for the bit clock and for the frame sync.

Samples arrive on a valid/ready handshake. The block takes one sample at the start of each slot that is not masked.

When `en` rises from idle, the block spends one lead bit period driving zero data. This gives an early-sync style room to pulse before the first data bit. The block then repeats frames until `en` is cleared. It finishes the frame in progress, with `active` held high, and then returns to idle. If no sample is offered at the start of an unmasked slot, that slot carries zeros and a sticky underrun flag is set.

Top module: `audio_frame_tx`

## Requirements
- R1: While reset is held, the outputs are `active`=0, `sdata`=0, `s_ready`=0 and `underrun`=0. `bclk` sits at `cfg_bclk_inv`, and `fsync` sits at its inactive level.
- R2: One bit period lasts 2×HALF system clocks. With no inversion, `bclk` is low for the first half of the bit and high for the second half. `sdata` changes only when `bclk` enters its first-half level, so it is stable across the sampling transition.
- R3: With `cfg_lsb_first`=1, bit 0 of a word is sent first. With `cfg_lsb_first`=0, bit W-1 is sent first.
- R4: Style 0 (`cfg_style`=0) uses an active-low sync that covers W bit periods. It starts on the last bit of the previous frame and ends before the last bit of slot 0.
- R5: Style 1 uses an active-high sync that covers exactly the W bits of slot 0.
- R6: Style 2 uses an active-high sync one bit wide, placed on the last bit of the frame, one bit before the first data bit.
- R7: Style 3 uses an active-high sync one bit wide, placed on the first data bit of the frame.
- R8: `cfg_bclk_inv` inverts `bclk`, and `cfg_fs_inv` inverts `fsync`. Each can be set alone or together with the other.
- R9: A frame holds `cfg_two_slots`+1 slots of W bits each. A slot whose bit in `cfg_slot_mask` is set (bit 0 for slot 0, bit 1 for slot 1) carries zeros and does not assert `s_ready`. Each unmasked slot takes exactly one sample, in slot order.
- R10: If `s_valid` is low when an unmasked slot starts, that slot carries zeros and `underrun` is set. `underrun` then stays set until reset.
- R11: After `en` is cleared, `active` stays high until the last bit of the current frame has been sent. No further bits follow after that.
- R12: `cfg_width` selects the word width W: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32.
- R13: A start from idle is preceded by one lead bit period with `sdata`=0. During that lead bit, `fsync` takes the value it would have on the last bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request; a clear takes effect at the frame end |
| cfg_style | input | 2 | Framing style 0..3 |
| cfg_width | input | 2 | Word width select |
| cfg_lsb_first | input | 1 | Send bit 0 first when set |
| cfg_two_slots | input | 1 | Two slots per frame when set, otherwise one |
| cfg_slot_mask | input | 2 | Per-slot mask |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_fs_inv | input | 1 | Invert the frame sync |
| s_data | input | 32 | Sample word, right-aligned |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample taken on this clock edge |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| active | output | 1 | Transmitter running |
| underrun | output | 1 | Sticky missing-sample flag |

## Verification
Two events can coincide on a single system clock edge. One is the frame-end decision that finishes a graceful stop. The other is the sample load of the next slot, together with its early sync pulse.

The bench clears `en` partway through the last frame of every case. It then checks three things:

- the count of captured bits is exactly the lead bit plus whole frames;
- the number of handshakes matches the number of slots the model says were loaded;
- `sdata` and `fsync` return to idle levels, with no extra sample taken.

Random configurations with short sample supplies also make underrun slots, masked slots and sample loads fall on adjacent slot boundaries.

// File: rtl/audio_frame_tx.sv
module audio_frame_tx #(
  parameter int HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  cfg_style,
  input  logic [1:0]  cfg_width,
  input  logic        cfg_lsb_first,
  input  logic        cfg_two_slots,
  input  logic [1:0]  cfg_slot_mask,
  input  logic        cfg_bclk_inv,
  input  logic        cfg_fs_inv,
  input  logic [31:0] s_data,
  input  logic        s_valid,
  output logic        s_ready,
  output logic        bclk,
  output logic        fsync,
  output logic        sdata,
  output logic        active,
  output logic        underrun
);
  localparam int PER = 2 * HALF;
  localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

  logic [CW-1:0] div_q;
  logic          run_q, lead_q, sd_q, fs_q, urun_q, slot_q;
  logic [4:0]    bit_q;
  logic [31:0]   word_q, word_n;

  function automatic logic fs_at(input logic [1:0] st, input logic [4:0] b,
                                 input logic s, input logic [4:0] lb, input logic ls);
    logic last;
    last = (b == lb) && (s == ls);
    case (st)
      2'd0:    fs_at = last || (!s && b != lb);
      2'd1:    fs_at = !s;
      2'd2:    fs_at = last;
      default: fs_at = !s && b == 5'd0;
    endcase
  endfunction

  logic [4:0] lastb, bit_nx, tgt_bit, idx;
  logic       tick, end_word, end_frame, stop, load, slot_nx, tgt_slot, fs_d, sd_d;

  assign lastb     = {cfg_width, 3'b111};
  assign tick      = run_q && (div_q == CW'(PER - 1));
  assign end_word  = (bit_q == lastb);
  assign end_frame = end_word && (slot_q == cfg_two_slots);
  assign stop      = tick && end_frame && !en;
  assign load      = tick && end_word && !stop;
  assign bit_nx    = end_word ? 5'd0 : bit_q + 5'd1;
  assign slot_nx   = end_word ? !end_frame : slot_q;
  assign s_ready   = load && !cfg_slot_mask[slot_nx];
  assign word_n    = load ? ((s_ready && s_valid) ? s_data : 32'd0) : word_q;
  assign tgt_bit   = run_q ? bit_nx : lastb;
  assign tgt_slot  = run_q ? slot_nx : cfg_two_slots;
  assign idx       = cfg_lsb_first ? tgt_bit : lastb - tgt_bit;
  assign sd_d      = word_n[idx];
  assign fs_d      = fs_at(cfg_style, tgt_bit, tgt_slot, lastb, cfg_two_slots);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      run_q  <= 1'b0;
      lead_q <= 1'b0;
      bit_q  <= '0;
      slot_q <= 1'b0;
      word_q <= '0;
      sd_q   <= 1'b0;
      fs_q   <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      if (!run_q) begin
        if (en) begin
          run_q  <= 1'b1;
          lead_q <= 1'b1;
          bit_q  <= lastb;
          slot_q <= cfg_two_slots;
          div_q  <= '0;
          sd_q   <= 1'b0;
          fs_q   <= fs_d;
        end
      end else if (tick) begin
        div_q  <= '0;
        lead_q <= 1'b0;
        if (stop) begin
          run_q <= 1'b0;
          sd_q  <= 1'b0;
          fs_q  <= 1'b0;
        end else begin
          bit_q  <= bit_nx;
          slot_q <= slot_nx;
          word_q <= word_n;
          sd_q   <= sd_d;
          fs_q   <= fs_d;
        end
      end else begin
        div_q <= div_q + CW'(1);
      end
      if (s_ready && !s_valid) urun_q <= 1'b1;
    end
  end

  assign bclk     = (div_q >= CW'(HALF)) ^ cfg_bclk_inv;
  assign fsync    = fs_q ^ (cfg_style == 2'd0) ^ cfg_fs_inv;
  assign sdata    = sd_q;
  assign active   = run_q;
  assign underrun = urun_q;
endmodule

// File: rtl/audio_frame_tx_chk.sv
module audio_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cfg_bclk_inv,
  input logic bclk,
  input logic sdata,
  input logic active,
  input logic s_ready,
  input logic underrun
);
  p_sdata_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> (!(bclk ^ cfg_bclk_inv) && $past(bclk ^ cfg_bclk_inv)));

  p_ready_when_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> active);

  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  p_stop_needs_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !$past(en));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!sdata && !s_ready));
endmodule

bind audio_frame_tx audio_frame_tx_chk i_chk (.*);

// File: tb/test_audio_frame_tx.sv
module test_audio_frame_tx;
  localparam int HALF = 2;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [1:0] cfg_style = 0, cfg_width = 0, cfg_slot_mask = 0;
  logic cfg_lsb_first = 0, cfg_two_slots = 0, cfg_bclk_inv = 0, cfg_fs_inv = 0;
  logic [31:0] s_data = 0;
  logic s_valid = 0;
  logic s_ready, bclk, fsync, sdata, active, underrun;

  audio_frame_tx #(.HALF(HALF)) i_audio_frame_tx (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int cyc = 0, log_n = 0, per_bad = 0, chg_bad = 0, last_edge = 0;
  logic log_sd [0:511];
  logic log_fs [0:511];
  logic prev_raw = 0, prev_sd = 0;
  int unsigned fd [0:63];
  int fn = 0, fi = 0, hs = 0;
  bit pend = 0, done = 0;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    logic raw;
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      summary();
    end
    raw = bclk ^ cfg_bclk_inv;
    if (raw && !prev_raw) begin
      if (log_n > 0 && cyc - last_edge != 2*HALF) per_bad++;
      last_edge = cyc;
      if (log_n < 512) begin log_sd[log_n] = sdata; log_fs[log_n] = fsync; end
      log_n++;
    end
    if (raw && sdata !== prev_sd) chg_bad++;
    prev_raw = raw; prev_sd = sdata;
  end

  always @(negedge clk) begin
    if (pend) begin fi++; pend = 0; end
    s_valid = (fi < fn);
    s_data  = (fi < 64) ? fd[fi] : 32'd0;
    if (s_valid && s_ready) begin pend = 1; hs++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit fs_exp(input int st, input int p, input int n, input int w);
    case (st)
      0: return (p == n-1) || (p < w-1);
      1: return p < w;
      2: return p == n-1;
      default: return p == 0;
    endcase
  endfunction

  function automatic string fs_tag(input int st);
    case (st)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_case(input int st, input int ws, input bit lsb, input bit two,
                          input int msk, input bit bi, input bit fin, input int nfr,
                          input int nsamp, input string dtag);
    int w, n, k, d_bad, f_bad, thr;
    bit pol, under;
    w = 8*(ws+1); n = w*(two+1); pol = (st == 0) ^ fin;
    rst_n = 0; en = 0;
    cfg_style = 2'(st); cfg_width = 2'(ws); cfg_lsb_first = lsb; cfg_two_slots = two;
    cfg_slot_mask = 2'(msk); cfg_bclk_inv = bi; cfg_fs_inv = fin;
    for (int i = 0; i < 64; i++) fd[i] = $urandom;
    fn = 0; fi = 0; pend = 0; hs = 0;
    repeat (3) @(negedge clk);
    chk(!active && !sdata && !s_ready && !underrun && bclk == bi && fsync == pol,
        "R1", "reset outputs", {active, sdata, s_ready, underrun, bclk, fsync},
        {4'b0, bi, pol});
    @(negedge clk); rst_n = 1; fn = nsamp;
    log_n = 0; per_bad = 0; chg_bad = 0;
    @(negedge clk); en = 1;
    thr = 1 + (nfr-1)*n + 2;
    wait (log_n >= thr);
    @(negedge clk); en = 0;
    wait (!active);
    repeat (6) @(negedge clk);
    chk(log_n == 1 + nfr*n, "R11", "bits sent after clear", log_n, 1 + nfr*n);
    chk(log_sd[0] == 0 && log_fs[0] == (fs_exp(st, n-1, n, w) ^ pol), "R13",
        "lead bit sd/fs", {log_sd[0], log_fs[0]}, {1'b0, fs_exp(st, n-1, n, w) ^ pol});
    k = 0; under = 0; d_bad = 0; f_bad = 0;
    for (int f = 0; f < nfr; f++) begin
      logic [31:0] wd;
      wd = 0;
      for (int p = 0; p < n; p++) begin
        int s, b, e;
        s = p / w; b = p % w;
        if (b == 0) begin
          if (msk[s]) wd = 0;
          else if (k < nsamp) begin wd = fd[k]; k++; end
          else begin wd = 0; under = 1; end
        end
        e = 1 + f*n + p;
        if (e < 512) begin
          if (log_sd[e] !== wd[lsb ? b : w-1-b]) d_bad++;
          if (log_fs[e] !== (fs_exp(st, p, n, w) ^ pol)) f_bad++;
        end
      end
    end
    chk(d_bad == 0, dtag, "data bit mismatches", d_bad, 0);
    chk(f_bad == 0, fs_tag(st), "frame sync mismatches", f_bad, 0);
    chk(hs == k, "R9", "samples taken", hs, k);
    chk(underrun == under, "R10", "underrun flag", underrun, under);
    chk(per_bad == 0 && chg_bad == 0, "R2", "period/edge faults", per_bad + chg_bad, 0);
    chk(bclk == bi && fsync == pol && !sdata, "R8", "idle levels after stop",
        {bclk, fsync, sdata}, {bi, pol, 1'b0});
  endtask

  initial begin
    void'($urandom(32'h5eed_a0d1));
    run_case(0, 1, 0, 1, 0, 0, 0, 3, 6, "R12");
    run_case(1, 2, 1, 1, 0, 0, 0, 3, 6, "R3");
    run_case(2, 3, 0, 1, 0, 0, 0, 2, 4, "R12");
    run_case(3, 0, 1, 1, 0, 0, 0, 3, 6, "R3");
    run_case(0, 1, 0, 1, 2, 0, 0, 3, 3, "R9");
    run_case(1, 0, 0, 1, 1, 0, 0, 3, 3, "R9");
    run_case(3, 1, 0, 1, 0, 0, 0, 3, 2, "R10");
    run_case(0, 1, 0, 1, 0, 1, 1, 2, 4, "R8");
    run_case(2, 0, 1, 1, 0, 1, 0, 2, 4, "R8");
    run_case(1, 0, 0, 0, 0, 0, 0, 3, 3, "R12");
    for (int r = 0; r < 8; r++)
      run_case(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 1'($urandom),
               1'($urandom), int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
               int'($urandom_range(2, 3)), int'($urandom_range(0, 8)), "R3");
    done = 1;
    summary();
  end
endmodule